// File: doc/BRIEF.md
# Accumulator-Group ALU Executor

This block carries out the eight accumulator-group operations of an 8-bit processor after the operand byte has been fetched elsewhere. It receives a 3-bit operation field, the 3-bit addressing-mode field, the operand byte and the current accumulator value. One cycle after it accepts a request, it returns the new accumulator value and a store request. In the same clock edge it updates the negative, zero, carry and overflow flags that it holds.

The block also owns the processor flag register. It can load that register from a status byte, and it presents the register as a packed status byte. A single-bit input marks a status byte that a software break is about to push. Decimal mode is a real flag. When it is set, the add and subtract operations apply BCD digit correction to the accumulator and to the carry.

Top module: `acc_group_exec`

## Requirements
- R1: `op_sel` selects the operation: 0 OR, 1 AND, 2 XOR, 3 add with carry, 4 store, 5 load, 6 compare, 7 subtract with borrow.
- R2: For OR, AND, XOR and load, `acc_out` receives the result. N takes bit 7 of the result, Z is set when the result is zero, and C and V are not changed.
- R3: Compare leaves `acc_out` equal to `acc_in`. N and Z come from `acc_in - operand` mod 256, and C is set when `acc_in >= operand` as unsigned numbers. V is not changed.
- R4: Add computes `acc_in + operand + C`. C receives the carry out. V is set when both inputs have the same sign and the result's sign differs from it.
- R5: Subtract behaves as add with the operand inverted, so C=1 means no borrow, and C after the operation is 1 when no borrow occurred.
- R6: When D (status bit 3) is 1, add and subtract correct the accumulator to packed BCD and C gives the decimal carry or no-borrow. N, Z and V follow the binary result.
- R7: Store with `addr_mode` other than 2 raises `store_req` with `store_data` equal to `acc_in`. Store with `addr_mode` equal to 2 raises no request. Neither form changes the accumulator or any flag.
- R8: `status_out` bits 7 to 0 are N, V, 1, brk, D, I, Z, C. Bit 5 always reads 1, and bit 4 equals `brk_mark`.
- R9: A pulse on `stat_wr` loads C, Z, I, D, V and N from bits 0, 1, 2, 3, 6 and 7 of `stat_din`. Bits 4 and 5 of `stat_din` are ignored.
- R10: While `rst_n` is low, `out_valid` and `store_req` are 0, `in_ready` is 1, and every flag is clear except I. `status_out` therefore reads 0x24 while `brk_mark` is 0.
- R11: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `out_valid` rises at that edge. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can take a request |
| op_sel | input | 3 | Operation field |
| addr_mode | input | 3 | Addressing-mode field; 2 means immediate |
| operand | input | 8 | Fetched operand byte |
| acc_in | input | 8 | Current accumulator |
| out_valid | output | 1 | Result registers hold a result |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | 8 | New accumulator value |
| store_req | output | 1 | Write of `store_data` requested |
| store_data | output | 8 | Byte to store |
| stat_wr | input | 1 | Load the flags from `stat_din` |
| stat_din | input | 8 | Status byte to load |
| brk_mark | input | 1 | Sets bit 4 of the packed byte |
| status_out | output | 8 | Packed status byte |

## Verification
Each operation is tried on operand pairs chosen to separate its flag rules. The logic operations get results with the top bit set and results of zero, with C and V preset to 1 so that an unwanted write to them shows up. The adds get signed overflow, carry-out wraparound to zero and a carry-in that crosses the sign boundary. The compares get equal, greater and smaller operands, which separates the unsigned carry from N. In decimal mode, the adds and subtracts get digit carries and digit borrows, so a missing nibble correction or a wrong digit chain gives a different byte. Both store modes are run, the status byte is loaded with all ones and then all zeros, and a stalled result is held against a second request.

// File: rtl/acc_group_pkg.sv
// Shared types for the accumulator-group executor.
// Assumes an 8-bit status byte; the data path width is set by the top module.
package acc_group_pkg;
    typedef enum logic [2:0] {
        OP_OR    = 3'd0,
        OP_AND   = 3'd1,
        OP_XOR   = 3'd2,
        OP_ADD   = 3'd3,
        OP_STORE = 3'd4,
        OP_LOAD  = 3'd5,
        OP_CMP   = 3'd6,
        OP_SUB   = 3'd7
    } op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam logic [2:0] MODE_IMM = 3'd2;
endpackage

// File: rtl/acc_group_bcd.sv
// Packed-BCD add/subtract with a ripple chain across decimal digits.
// Assumes DATA_W is a multiple of 4 and that the inputs are valid BCD.
// For subtract, ci=1 means no incoming borrow and co=1 means no borrow out.
module acc_group_bcd #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              ci,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              co
);
    localparam int NDIG = DATA_W / 4;

    logic [NDIG:0] link;   // carry for add, borrow for subtract

    // Seed the digit chain from the incoming carry.
    assign link[0] = sub ? ~ci : ci;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [5:0] t;
        // One digit: binary nibble sum or difference, then a correction of 6.
        always_comb begin
            if (sub) begin
                t = {2'b00, a[4*g +: 4]} - {2'b00, b[4*g +: 4]} - {5'b0, link[g]};
                link[g+1] = t[5];
                if (t[5]) t = t - 6'd6;
            end else begin
                t = {2'b00, a[4*g +: 4]} + {2'b00, b[4*g +: 4]} + {5'b0, link[g]};
                if (t > 6'd9) t = t + 6'd6;
                link[g+1] = (t > 6'd15);
            end
            res[4*g +: 4] = t[3:0];
        end
    end

    // Convert the last digit's carry or borrow back to carry sense.
    assign co = sub ? ~link[NDIG] : link[NDIG];
endmodule

// File: rtl/acc_group_alu.sv
// Combinational datapath for the eight accumulator-group operations.
// Produces the accumulator result, candidate flags, per-flag update enables
// and the store request. Assumes D only affects add and subtract.
module acc_group_alu
    import acc_group_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DEC_EN = 1'b1
) (
    input  logic [2:0]        op,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] opd,
    input  logic [DATA_W-1:0] acc,
    input  logic              cin,
    input  logic              dec,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              c,
    output logic              v,
    output logic              upd_nz,
    output logic              upd_c,
    output logic              upd_v,
    output logic              store
);
    localparam int MSB = DATA_W - 1;

    logic              inv_b;
    logic              cin_eff;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] bcd_res;
    logic              bcd_co;
    logic              use_bcd;

    // Operand inversion for subtract and compare; compare forces carry in.
    always_comb begin
        inv_b   = (op == OP_SUB) || (op == OP_CMP);
        b_eff   = inv_b ? ~opd : opd;
        cin_eff = (op == OP_CMP) ? 1'b1 : cin;
        sum     = {1'b0, acc} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
    end

    if (DEC_EN) begin : g_bcd
        acc_group_bcd #(.DATA_W(DATA_W)) u_bcd (
            .a   (acc),
            .b   (opd),
            .ci  (cin),
            .sub (op == OP_SUB),
            .res (bcd_res),
            .co  (bcd_co)
        );
        assign use_bcd = dec && ((op == OP_ADD) || (op == OP_SUB));
    end else begin : g_nobcd
        assign bcd_res = '0;
        assign bcd_co  = 1'b0;
        assign use_bcd = 1'b0;
    end

    // Select the result and flags and say which flags the operation owns.
    always_comb begin
        res    = acc;
        upd_nz = 1'b1;
        upd_c  = 1'b0;
        upd_v  = 1'b0;
        store  = 1'b0;
        n      = 1'b0;
        z      = 1'b0;
        c      = sum[DATA_W];
        v      = (acc[MSB] == b_eff[MSB]) && (sum[MSB] != acc[MSB]);
        unique case (op_e'(op))
            OP_OR:   res = acc | opd;
            OP_AND:  res = acc & opd;
            OP_XOR:  res = acc ^ opd;
            OP_LOAD: res = opd;
            OP_CMP:  upd_c = 1'b1;
            OP_STORE: begin
                upd_nz = 1'b0;
                store  = (mode != MODE_IMM);
            end
            OP_ADD, OP_SUB: begin
                res   = use_bcd ? bcd_res : sum[MSB:0];
                c     = use_bcd ? bcd_co  : sum[DATA_W];
                upd_c = 1'b1;
                upd_v = 1'b1;
            end
            default: res = acc;
        endcase
        // N and Z follow the binary value for arithmetic, the result otherwise.
        if (op == OP_CMP || op == OP_ADD || op == OP_SUB) begin
            n = sum[MSB];
            z = (sum[MSB:0] == '0);
        end else begin
            n = res[MSB];
            z = (res == '0);
        end
    end
endmodule

// File: rtl/acc_group_status.sv
// Packs the flag register into the status byte and unpacks a loaded byte.
// Bit 5 reads as 1; bit 4 comes from the break marker and is never stored.
module acc_group_status
    import acc_group_pkg::*;
(
    input  flags_t     flags,
    input  logic       brk,
    input  logic [7:0] din,
    output logic [7:0] packed_byte,
    output flags_t     loaded
);
    // Bit placement that the rest of the processor decodes.
    always_comb begin
        packed_byte = {flags.n, flags.v, 1'b1, brk, flags.d, flags.i, flags.z, flags.c};
        loaded.n    = din[7];
        loaded.v    = din[6];
        loaded.d    = din[3];
        loaded.i    = din[2];
        loaded.z    = din[1];
        loaded.c    = din[0];
    end
endmodule

// File: rtl/acc_group_exec.sv
// Accumulator-group executor top: accepts one request per handshake and
// registers the result for one cycle later. Holds the flag register.
// Assumes the caller does not pulse stat_wr in a cycle where a request is
// accepted; if it does, the request's flag update wins.
module acc_group_exec
    import acc_group_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DEC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        op_sel,
    input  logic [2:0]        addr_mode,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] acc_out,
    output logic              store_req,
    output logic [DATA_W-1:0] store_data,
    input  logic              stat_wr,
    input  logic [7:0]        stat_din,
    input  logic              brk_mark,
    output logic [7:0]        status_out
);
    flags_t            flg_q;
    flags_t            flg_load;
    logic              accept;
    logic [DATA_W-1:0] alu_res;
    logic              alu_n, alu_z, alu_c, alu_v;
    logic              upd_nz, upd_c, upd_v, alu_store;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    acc_group_alu #(.DATA_W(DATA_W), .DEC_EN(DEC_EN)) u_alu (
        .op     (op_sel),
        .mode   (addr_mode),
        .opd    (operand),
        .acc    (acc_in),
        .cin    (flg_q.c),
        .dec    (flg_q.d),
        .res    (alu_res),
        .n      (alu_n),
        .z      (alu_z),
        .c      (alu_c),
        .v      (alu_v),
        .upd_nz (upd_nz),
        .upd_c  (upd_c),
        .upd_v  (upd_v),
        .store  (alu_store)
    );

    acc_group_status u_stat (
        .flags       (flg_q),
        .brk         (brk_mark),
        .din         (stat_din),
        .packed_byte (status_out),
        .loaded      (flg_load)
    );

    // Result registers and the output valid flag of the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            acc_out    <= '0;
            store_req  <= 1'b0;
            store_data <= '0;
        end else if (accept) begin
            out_valid  <= 1'b1;
            acc_out    <= alu_res;
            store_req  <= alu_store;
            store_data <= acc_in;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
            store_req  <= 1'b0;
        end
    end

    // Flag register: reset state, operation updates, or a status load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};
        end else if (accept) begin
            if (upd_nz) begin
                flg_q.n <= alu_n;
                flg_q.z <= alu_z;
            end
            if (upd_c) flg_q.c <= alu_c;
            if (upd_v) flg_q.v <= alu_v;
        end else if (stat_wr) begin
            flg_q <= flg_load;
        end
    end
endmodule

// File: rtl/acc_group_exec_chk.sv
// Property checker for acc_group_exec, attached by the bind below.
// Observes only the ports of the top module.
module acc_group_exec_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        op_sel,
    input logic [2:0]        addr_mode,
    input logic [DATA_W-1:0] acc_in,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] acc_out,
    input logic              store_req,
    input logic [DATA_W-1:0] store_data,
    input logic [7:0]        status_out
);
    logic acc_ok;
    assign acc_ok = in_valid && in_ready;

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(acc_out) && $stable(store_req)));

    // R3
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_sel == 3'd6) |=> (acc_out == $past(acc_in)));

    // R7
    imm_store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_sel == 3'd4 && addr_mode == 3'd2) |=>
        (!store_req && {status_out[7:5], status_out[3:0]} ==
                       {$past(status_out[7:5]), $past(status_out[3:0])}));

    // R7
    store_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && op_sel == 3'd4 && addr_mode != 3'd2) |=>
        (store_req && store_data == $past(acc_in)));

    // R2
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd2 || op_sel == 3'd5)) |=>
        (status_out[0] == $past(status_out[0]) && status_out[6] == $past(status_out[6])));

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !status_out[3] && op_sel != 3'd4 && op_sel != 3'd6) |=>
        (status_out[1] == (acc_out == '0)));
endmodule

bind acc_group_exec acc_group_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .op_sel     (op_sel),
    .addr_mode  (addr_mode),
    .acc_in     (acc_in),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .acc_out    (acc_out),
    .store_req  (store_req),
    .store_data (store_data),
    .status_out (status_out)
);

// File: tb/sim_acc_group_exec.sv
`timescale 1ns/1ps
module sim_acc_group_exec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] op_sel = '0;
    logic [2:0] addr_mode = '0;
    logic [7:0] operand = '0;
    logic [7:0] acc_in = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] acc_out;
    logic       store_req;
    logic [7:0] store_data;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_din = '0;
    logic       brk_mark = 1'b0;
    logic [7:0] status_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_group_exec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_sel(op_sel), .addr_mode(addr_mode), .operand(operand), .acc_in(acc_in),
        .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out),
        .store_req(store_req), .store_data(store_data), .stat_wr(stat_wr),
        .stat_din(stat_din), .brk_mark(brk_mark), .status_out(status_out)
    );

    // Vector: op(3) mode(3) operand(8) acc(8) c(1) d(1) v(1)
    localparam int NV = 20;
    localparam logic [24:0] VEC [NV] = '{
        {3'd0, 3'd1, 8'hF0, 8'h0F, 1'b1, 1'b0, 1'b1},
        {3'd1, 3'd1, 8'h0F, 8'hF0, 1'b1, 1'b0, 1'b1},
        {3'd2, 3'd2, 8'hFF, 8'hAA, 1'b0, 1'b0, 1'b0},
        {3'd3, 3'd2, 8'h50, 8'h50, 1'b0, 1'b0, 1'b0},
        {3'd3, 3'd1, 8'h01, 8'hFF, 1'b0, 1'b0, 1'b0},
        {3'd3, 3'd1, 8'h00, 8'h7F, 1'b1, 1'b0, 1'b0},
        {3'd4, 3'd1, 8'h99, 8'h3C, 1'b1, 1'b0, 1'b1},
        {3'd4, 3'd2, 8'h99, 8'h3C, 1'b1, 1'b0, 1'b1},
        {3'd5, 3'd2, 8'h80, 8'h11, 1'b1, 1'b0, 1'b0},
        {3'd5, 3'd2, 8'h00, 8'h11, 1'b0, 1'b0, 1'b1},
        {3'd6, 3'd2, 8'h40, 8'h40, 1'b0, 1'b0, 1'b1},
        {3'd6, 3'd2, 8'h20, 8'h10, 1'b1, 1'b0, 1'b0},
        {3'd6, 3'd2, 8'h10, 8'h90, 1'b0, 1'b1, 1'b0},
        {3'd7, 3'd2, 8'hF0, 8'h50, 1'b1, 1'b0, 1'b0},
        {3'd7, 3'd2, 8'h01, 8'h80, 1'b1, 1'b0, 1'b0},
        {3'd7, 3'd2, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0},
        {3'd3, 3'd2, 8'h46, 8'h58, 1'b1, 1'b1, 1'b0},
        {3'd3, 3'd2, 8'h34, 8'h12, 1'b0, 1'b1, 1'b0},
        {3'd7, 3'd2, 8'h12, 8'h46, 1'b1, 1'b1, 1'b0},
        {3'd7, 3'd2, 8'h34, 8'h21, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic d);
        if (d && (op == 3'd3 || op == 3'd7)) return "R6";
        case (op)
            3'd3: return "R4";
            3'd4: return "R7";
            3'd6: return "R3";
            3'd7: return "R5";
            default: return "R2";
        endcase
    endfunction

    // Reference model written from the requirements.
    task automatic model(input logic [2:0] op, input logic [2:0] mode, input int opd,
                         input int a, input int c, input int d, input int v,
                         output int res, output int st, output int sreq);
        int n, z, cc, vv, b, sum, bin, lo, hi, bor;
        n = 0; z = 0; cc = c; vv = v; res = a; sreq = 0;
        bin = a;
        case (op)
            3'd0: res = a | opd;
            3'd1: res = a & opd;
            3'd2: res = a ^ opd;
            3'd5: res = opd;
            3'd4: sreq = (mode != 3'd2);
            3'd6: begin bin = (a - opd) & 255; cc = (a >= opd); end
            default: begin
                b = (op == 3'd7) ? (~opd & 255) : opd;
                sum = a + b + c;
                bin = sum & 255;
                cc = sum >> 8;
                vv = (((a ^ b) & 128) == 0) && (((a ^ bin) & 128) != 0);
                res = bin;
                if (d != 0 && op == 3'd3) begin
                    lo = (a & 15) + (opd & 15) + c;
                    if (lo > 9) lo += 6;
                    hi = (a >> 4) + (opd >> 4) + (lo > 15 ? 1 : 0);
                    if (hi > 9) hi += 6;
                    cc = (hi > 15);
                    res = ((hi & 15) << 4) | (lo & 15);
                end else if (d != 0) begin
                    lo = (a & 15) - (opd & 15) - (1 - c);
                    bor = (lo < 0);
                    if (lo < 0) lo -= 6;
                    hi = (a >> 4) - (opd >> 4) - bor;
                    if (hi < 0) hi -= 6;
                    res = ((hi & 15) << 4) | (lo & 15);
                end
            end
        endcase
        if (op == 3'd0 || op == 3'd1 || op == 3'd2 || op == 3'd5) bin = res;
        if (op != 3'd4) begin
            n = (bin >> 7) & 1;
            z = (bin == 0);
        end
        st = (n << 7) | (vv << 6) | 32 | (d << 3) | 4 | (z << 1) | cc;
    endtask

    task automatic load_status(input logic [7:0] b);
        @(negedge clk);
        stat_wr = 1'b1; stat_din = b;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    initial begin
        int res, st, sreq;
        string rq;
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", "out_valid", out_valid, 0);
        check("R10", "status_out", status_out, 8'h24);
        check("R10", "in_ready", in_ready, 1);
        check("R10", "store_req", store_req, 0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: R1 op mapping plus R2..R7 per operation
        for (int k = 0; k < NV; k++) begin
            logic [2:0] vop, vmode;
            logic [7:0] vopd, vacc;
            logic vc, vd, vv;
            {vop, vmode, vopd, vacc, vc, vd, vv} = VEC[k];
            load_status({1'b0, vv, 1'b1, 1'b0, vd, 1'b1, 1'b0, vc});
            in_valid = 1'b1; op_sel = vop; addr_mode = vmode; operand = vopd; acc_in = vacc;
            @(negedge clk);
            in_valid = 1'b0;
            model(vop, vmode, vopd, vacc, vc, vd, vv, res, st, sreq);
            rq = req_of(vop, vd);
            check("R11", "out_valid", out_valid, 1);
            check({rq, "/R1"}, $sformatf("acc_out v%0d", k), acc_out, res);
            check({rq, "/R8"}, $sformatf("status v%0d", k), status_out, st);
            check(rq, $sformatf("store_req v%0d", k), store_req, sreq);
            if (sreq != 0) check("R7", "store_data", store_data, vacc);
        end

        // R9: load all ones, bits 4 and 5 ignored; R8: brk_mark drives bit 4
        load_status(8'hFF);
        check("R9", "status after FF", status_out, 8'hEF);
        brk_mark = 1'b1; #1;
        check("R8", "brk bit set", status_out, 8'hFF);
        load_status(8'h00);
        check("R9", "status after 00 with brk", status_out, 8'h30);
        brk_mark = 1'b0; #1;
        check("R8", "bit 5 stays", status_out, 8'h20);

        // R11: stall holds the result and blocks a second request
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'd5; addr_mode = 3'd2; operand = 8'h5A;
        @(negedge clk);
        operand = 8'h00;
        check("R11", "in_ready stalled", in_ready, 0);
        @(negedge clk);
        check("R11", "acc held", acc_out, 8'h5A);
        check("R11", "valid held", out_valid, 1);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        check("R11", "valid drops", out_valid, 0);
        check("R11", "second not taken", acc_out, 8'h5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule